// File: doc/BRIEF.md
# Static LCD Segment and Backplane Driver

This block turns a held conversion result into the drive lines of a static 3-1/2 digit liquid crystal display. It produces two kinds of output. The first is a backplane square wave divided down from the oscillator clock. The second is one line per segment: seven segments on each of the three lower digits, a single line for the leading "1", and a minus sign. A segment is shown by driving its line opposite to the backplane. A segment is hidden by driving its line equal to the backplane. This keeps the average voltage across every segment near zero.

A converter delivers its result on a one-cycle load strobe. The result is three BCD digits, a flag for the leading "1", a sign bit and an overrange flag. The driver holds the result until the next strobe.

Segment lines change only in the cycle in which the backplane toggles, so no segment shifts within a half-period. Two inputs override the normal display:
- An overrange result leaves only the leading "1" and the sign.
- A lamp-test input lights every segment, so the display reads -1888.

Top module: `lcd_static_driver`

## Requirements
- R1: `bp` is a square wave that toggles every BP_DIV/2 clock cycles (BP_DIV=800 gives oscillator/800). It is low for the first BP_DIV/2 cycles after reset.
- R2: Segment lines and `bp` are related as follows: a lit segment's line equals the inverse of `bp`, and a dark segment's line equals `bp`.
- R3: In every `seg_*` digit group, bit 0 is segment A (top), bit 1 is B (upper right), bit 2 is C (lower right), bit 3 is D (bottom), bit 4 is E (lower left), bit 5 is F (upper left) and bit 6 is G (middle). Each lower digit shows BCD codes 0 to 9 in the usual seven-segment shapes. Codes 10 to 15 leave the digit dark.
- R4: `seg_thou` is lit when the held thousands flag is 1 and dark when it is 0.
- R5: `seg_minus` is lit exactly when the held sign bit is 1.
- R6: The digits and flags are captured when `res_load` is high at a clock edge. They are held unchanged until the next load, and input changes without a load have no effect. A captured value appears from the second `bp` toggle after the load at the latest.
- R7: Segment lines change only in a cycle in which `bp` also changes.
- R8: While the held overrange flag is set, all three lower digits are dark, `seg_thou` is lit and `seg_minus` follows the held sign.
- R9: `lamp_test` high at a `bp` toggle lights every segment line for the following half-period, overriding the overrange flag and the held value.
- R10: Synchronous active-low reset drives `bp` and every segment line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_load | input | 1 | One-cycle strobe that captures a result |
| res_units | input | 4 | BCD units digit |
| res_tens | input | 4 | BCD tens digit |
| res_hund | input | 4 | BCD hundreds digit |
| res_thou | input | 1 | Leading "1" flag |
| res_neg | input | 1 | Sign bit, 1 = negative |
| res_ovr | input | 1 | Overrange flag |
| lamp_test | input | 1 | Light every segment |
| bp | output | 1 | Backplane square wave |
| seg_units | output | 7 | Units digit segment lines, bit 0 = A ... bit 6 = G |
| seg_tens | output | 7 | Tens digit segment lines |
| seg_hund | output | 7 | Hundreds digit segment lines |
| seg_thou | output | 1 | Both halves of the leading "1" |
| seg_minus | output | 1 | Minus sign line |

## Verification
The assertions observe each half-period at the cycle in which `bp` toggles. They assume that the lamp-test level and the held result seen one cycle before that toggle decide the pattern shown for the whole half-period. The stimulus respects this by changing `lamp_test` and strobing `res_load` only on falling clock edges, well inside a half-period. It then waits for two backplane toggles before sampling. The divider parameter in the bench is even and small, so the period check counts whole half-periods in few cycles.

// File: rtl/lcd_drv_pkg.sv
`timescale 1ns/1ps
// lcd_drv_pkg: shared sizes and types for the static LCD driver.
// Assumes three lower seven-segment digits plus a leading "1" and a sign.
package lcd_drv_pkg;
    localparam int SEG_PER_DIGIT = 7;
    localparam int LOWER_DIGITS  = 3;
    localparam int BCD_W         = 4;
    localparam int PAT_W         = LOWER_DIGITS * SEG_PER_DIGIT + 2;
    localparam int THOU_BIT      = LOWER_DIGITS * SEG_PER_DIGIT;
    localparam int MINUS_BIT     = THOU_BIT + 1;

    typedef logic [SEG_PER_DIGIT-1:0] seg7_t;

    typedef struct packed {
        logic                               neg;
        logic                               ovr;
        logic                               thou;
        logic [LOWER_DIGITS-1:0][BCD_W-1:0] bcd;   // [0]=units .. [2]=hundreds
    } result_t;
endpackage

// File: rtl/lcd_bp_divider.sv
`timescale 1ns/1ps
// lcd_bp_divider: divides the oscillator clock into the backplane square wave.
// Assumes BP_DIV is even and at least 2. The tick output is high in the cycle
// before bp toggles, so downstream registers can change together with bp.
module lcd_bp_divider #(
    parameter int BP_DIV = 800
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic bp
);
    localparam int HALF  = BP_DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    // Half-period counter that wraps after HALF cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Backplane level, toggled at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    bp <= 1'b0;
        else if (tick) bp <= ~bp;
    end
endmodule

// File: rtl/lcd_result_latch.sv
`timescale 1ns/1ps
// lcd_result_latch: holds the conversion result between load strobes.
// Assumes the load strobe is synchronous to clk.
module lcd_result_latch
    import lcd_drv_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  result_t din,
    output result_t dout
);
    // Capture on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/lcd_digit_decode.sv
`timescale 1ns/1ps
// lcd_digit_decode: BCD to seven-segment, bit 0 = A (top) through bit 6 = G.
// Codes above 9 give a dark digit. Purely combinational.
module lcd_digit_decode
    import lcd_drv_pkg::*;
(
    input  logic [BCD_W-1:0] bcd,
    output seg7_t            seg
);
    // Map one BCD code to its lit segments.
    always_comb begin
        unique case (bcd)
            4'd0:    seg = 7'b011_1111;
            4'd1:    seg = 7'b000_0110;
            4'd2:    seg = 7'b101_1011;
            4'd3:    seg = 7'b100_1111;
            4'd4:    seg = 7'b110_0110;
            4'd5:    seg = 7'b110_1101;
            4'd6:    seg = 7'b111_1101;
            4'd7:    seg = 7'b000_0111;
            4'd8:    seg = 7'b111_1111;
            4'd9:    seg = 7'b110_1111;
            default: seg = 7'b000_0000;
        endcase
    end
endmodule

// File: rtl/lcd_phase_drive.sv
`timescale 1ns/1ps
// lcd_phase_drive: registers the segment lines, each in or out of phase with
// the backplane. Loads only on tick, the cycle in which bp is about to toggle,
// so lines and bp move in the same clock edge. Lit = opposite of new bp.
module lcd_phase_drive #(
    parameter int WIDTH = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bp,
    input  logic [WIDTH-1:0] on_pat,
    output logic [WIDTH-1:0] drive
);
    // New bp is ~bp: lit lines take bp's current level, dark lines take ~bp.
    always_ff @(posedge clk) begin
        if (!rst_n)    drive <= '0;
        else if (tick) drive <= ~(on_pat ^ {WIDTH{bp}});
    end
endmodule

// File: rtl/lcd_static_driver.sv
`timescale 1ns/1ps
// lcd_static_driver: static 3-1/2 digit LCD driver top level.
// Holds a result on res_load, decodes it, applies overrange blanking and the
// lamp-test override, and drives segments in phase (dark) or anti-phase (lit)
// with a backplane of clk/BP_DIV. Assumes BP_DIV is even and a single clock.
module lcd_static_driver
    import lcd_drv_pkg::*;
#(
    parameter int BP_DIV = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       res_load,
    input  logic [3:0] res_units,
    input  logic [3:0] res_tens,
    input  logic [3:0] res_hund,
    input  logic       res_thou,
    input  logic       res_neg,
    input  logic       res_ovr,
    input  logic       lamp_test,
    output logic       bp,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_hund,
    output logic       seg_thou,
    output logic       seg_minus
);
    result_t           res_in;
    result_t           held;
    logic              tick;
    seg7_t             dec [LOWER_DIGITS];
    logic [PAT_W-1:0]  on_pat;
    logic [PAT_W-1:0]  drive;
    logic              lat_neg;
    logic              lat_ovr;

    // Gather the result fields into the shared struct.
    always_comb begin
        res_in.neg    = res_neg;
        res_in.ovr    = res_ovr;
        res_in.thou   = res_thou;
        res_in.bcd[0] = res_units;
        res_in.bcd[1] = res_tens;
        res_in.bcd[2] = res_hund;
    end

    lcd_bp_divider #(.BP_DIV(BP_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .bp    (bp)
    );

    lcd_result_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (res_load),
        .din   (res_in),
        .dout  (held)
    );

    assign lat_neg = held.neg;
    assign lat_ovr = held.ovr;

    for (genvar d = 0; d < LOWER_DIGITS; d++) begin : g_digit
        lcd_digit_decode u_dec (
            .bcd (held.bcd[d]),
            .seg (dec[d])
        );
        // Lower digits go dark on overrange and fully lit under lamp test.
        always_comb begin
            if (lamp_test)    on_pat[d*SEG_PER_DIGIT +: SEG_PER_DIGIT] = '1;
            else if (lat_ovr) on_pat[d*SEG_PER_DIGIT +: SEG_PER_DIGIT] = '0;
            else              on_pat[d*SEG_PER_DIGIT +: SEG_PER_DIGIT] = dec[d];
        end
    end

    // Leading "1" and sign selection.
    always_comb begin
        on_pat[THOU_BIT]  = lamp_test | held.thou | lat_ovr;
        on_pat[MINUS_BIT] = lamp_test | lat_neg;
    end

    lcd_phase_drive #(.WIDTH(PAT_W)) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .bp     (bp),
        .on_pat (on_pat),
        .drive  (drive)
    );

    assign seg_units = drive[0*SEG_PER_DIGIT +: SEG_PER_DIGIT];
    assign seg_tens  = drive[1*SEG_PER_DIGIT +: SEG_PER_DIGIT];
    assign seg_hund  = drive[2*SEG_PER_DIGIT +: SEG_PER_DIGIT];
    assign seg_thou  = drive[THOU_BIT];
    assign seg_minus = drive[MINUS_BIT];
endmodule

// File: rtl/lcd_static_driver_chk.sv
`timescale 1ns/1ps
// lcd_static_driver_chk: timing and pattern properties of the LCD driver,
// bound to the top. Observes each half-period at the cycle bp toggles.
module lcd_static_driver_chk #(
    parameter int BP_DIV = 800
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lamp_test,
    input logic       lat_neg,
    input logic       lat_ovr,
    input logic       bp,
    input logic [6:0] seg_units,
    input logic [6:0] seg_tens,
    input logic [6:0] seg_hund,
    input logic       seg_thou,
    input logic       seg_minus
);
    localparam int HALF = BP_DIV / 2;
    localparam int CW   = $clog2(HALF + 1) + 1;
    localparam logic [CW-1:0] HALF_C = CW'(HALF);

    logic [CW-1:0] since;
    logic          bp_prev;
    logic [22:0]   lines;

    assign lines = {seg_minus, seg_thou, seg_hund, seg_tens, seg_units};

    // Cycles since the last backplane change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since   <= '0;
            bp_prev <= 1'b0;
        end else begin
            bp_prev <= bp;
            since   <= (bp != bp_prev) ? CW'(1) : since + 1'b1;
        end
    end

    // R1
    bp_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp != bp_prev) |-> since == HALF_C);

    // R1
    bp_no_late_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        since <= HALF_C);

    // R7
    seg_change_on_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lines) |-> !$stable(bp));

    // R9
    lamp_all_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bp) && $past(lamp_test)) |-> (lines ^ {23{bp}}) == '1);

    // R8
    ovr_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bp) && $past(lat_ovr) && !$past(lamp_test)) |->
        ({seg_hund, seg_tens, seg_units} == {21{bp}} && seg_thou == !bp));

    // R5
    minus_follows_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bp) && !$past(lamp_test)) |-> (seg_minus ^ bp) == $past(lat_neg));
endmodule

bind lcd_static_driver lcd_static_driver_chk #(.BP_DIV(BP_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lamp_test (lamp_test),
    .lat_neg   (lat_neg),
    .lat_ovr   (lat_ovr),
    .bp        (bp),
    .seg_units (seg_units),
    .seg_tens  (seg_tens),
    .seg_hund  (seg_hund),
    .seg_thou  (seg_thou),
    .seg_minus (seg_minus)
);

// File: tb/lcd_static_driver_test.sv
`timescale 1ns/1ps
// Bench for lcd_static_driver: table-driven display vectors, then directed
// checks of reset, period, phase, hold, timing and lamp test.
module lcd_static_driver_test;
    localparam int BP_DIV = 8;
    localparam int HALF   = BP_DIV / 2;
    localparam int NVEC   = 9;
    // {thou, neg, ovr, hund, tens, units}
    localparam logic [14:0] VEC [NVEC] = '{
        {3'b000, 4'd0, 4'd0, 4'd0},
        {3'b010, 4'd1, 4'd2, 4'd3},
        {3'b100, 4'd4, 4'd5, 4'd6},
        {3'b110, 4'd7, 4'd8, 4'd9},
        {3'b000, 4'd9, 4'd9, 4'd9},
        {3'b100, 4'd0, 4'd0, 4'd0},
        {3'b010, 4'hA, 4'hF, 4'hC},
        {3'b001, 4'd5, 4'd5, 4'd5},
        {3'b011, 4'd8, 4'd8, 4'd8}
    };
    localparam logic [6:0] SA = 7'h01, SB = 7'h02, SC = 7'h04, SD = 7'h08,
                           SE = 7'h10, SF = 7'h20, SG = 7'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_load = 1'b0;
    logic [3:0] res_units = '0, res_tens = '0, res_hund = '0;
    logic res_thou = 1'b0, res_neg = 1'b0, res_ovr = 1'b0, lamp_test = 1'b0;
    logic bp, seg_thou, seg_minus;
    logic [6:0] seg_units, seg_tens, seg_hund;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_static_driver #(.BP_DIV(BP_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .res_load(res_load),
        .res_units(res_units), .res_tens(res_tens), .res_hund(res_hund),
        .res_thou(res_thou), .res_neg(res_neg), .res_ovr(res_ovr),
        .lamp_test(lamp_test), .bp(bp), .seg_units(seg_units),
        .seg_tens(seg_tens), .seg_hund(seg_hund), .seg_thou(seg_thou),
        .seg_minus(seg_minus)
    );

    function automatic logic [6:0] shape(input logic [3:0] c);
        case (c)
            4'd0: shape = SA|SB|SC|SD|SE|SF;
            4'd1: shape = SB|SC;
            4'd2: shape = SA|SB|SG|SE|SD;
            4'd3: shape = SA|SB|SG|SC|SD;
            4'd4: shape = SF|SG|SB|SC;
            4'd5: shape = SA|SF|SG|SC|SD;
            4'd6: shape = SA|SF|SG|SE|SC|SD;
            4'd7: shape = SA|SB|SC;
            4'd8: shape = 7'h7F;
            4'd9: shape = SA|SB|SC|SD|SF|SG;
            default: shape = 7'h00;
        endcase
    endfunction

    function automatic logic [20:0] lit_lower();
        return {seg_hund, seg_tens, seg_units} ^ {21{bp}};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_bp();
        logic b;
        b = bp;
        while (bp == b) @(negedge clk);
    endtask

    task automatic load(input logic [14:0] v);
        @(negedge clk);
        {res_thou, res_neg, res_ovr, res_hund, res_tens, res_units} = v;
        res_load = 1'b1;
        @(negedge clk);
        res_load = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [20:0] snap;
        int n;
        // R10 reset state
        repeat (3) @(negedge clk);
        chk("R10 bp in reset", {31'd0, bp}, 32'd0);
        chk("R10 lines in reset", {9'd0, seg_minus, seg_thou, seg_hund, seg_tens, seg_units}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bp low after reset", {31'd0, bp}, 32'd0);

        // R1 half-period length
        wait_bp();
        n = 0;
        begin
            logic b;
            b = bp;
            while (bp == b) begin @(negedge clk); n++; end
        end
        chk("R1 half period", n, HALF);

        // Table of display vectors
        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] v;
            logic [20:0] expl;
            v = VEC[i];
            load(v);
            wait_bp(); wait_bp();
            expl = v[12] ? 21'd0 : {shape(v[11:8]), shape(v[7:4]), shape(v[3:0])};
            chk(v[12] ? "R8 lower digits" : "R3 lower digits", {11'd0, lit_lower()}, {11'd0, expl});
            chk(v[12] ? "R8 thousands" : "R4 thousands", {31'd0, seg_thou ^ bp}, {31'd0, v[14] | v[12]});
            chk("R5 minus", {31'd0, seg_minus ^ bp}, {31'd0, v[13]});
        end

        // R2 raw phase: units=1 lights B,C only
        load({3'b000, 4'hA, 4'hA, 4'd1});
        wait_bp(); wait_bp();
        while (bp != 1'b0) @(negedge clk);
        chk("R2 units lines at bp low", {25'd0, seg_units}, 32'h06);
        chk("R2 dark line equals bp low", {31'd0, seg_thou}, 32'd0);
        wait_bp();
        chk("R2 units lines at bp high", {25'd0, seg_units}, 32'h79);
        chk("R2 dark line equals bp high", {31'd0, seg_thou}, 32'd1);

        // R6 inputs change without load: display held
        load({3'b000, 4'd3, 4'd2, 4'd1});
        wait_bp(); wait_bp();
        @(negedge clk);
        {res_thou, res_neg, res_ovr, res_hund, res_tens, res_units} = {3'b111, 4'd9, 4'd9, 4'd9};
        wait_bp(); wait_bp(); wait_bp();
        chk("R6 held digits", {11'd0, lit_lower()}, {11'd0, shape(4'd3), shape(4'd2), shape(4'd1)});
        chk("R6 held sign", {31'd0, seg_minus ^ bp}, 32'd0);

        // R7 and R9: lamp test mid half-period waits for next bp toggle
        wait_bp();
        @(negedge clk);
        snap = {seg_hund, seg_tens, seg_units};
        lamp_test = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R7 lines stable inside half period", {11'd0, seg_hund, seg_tens, seg_units}, {11'd0, snap});
        wait_bp();
        chk("R9 all lower lit", {11'd0, lit_lower()}, {11'd0, 21'h1FFFFF});
        chk("R9 thousands and minus lit", {30'd0, seg_thou ^ bp, seg_minus ^ bp}, 32'd3);

        // R9 lamp test overrides overrange
        load({3'b001, 4'd1, 4'd1, 4'd1});
        wait_bp(); wait_bp();
        chk("R9 lamp over overrange", {11'd0, lit_lower()}, {11'd0, 21'h1FFFFF});
        lamp_test = 1'b0;
        wait_bp(); wait_bp();
        chk("R8 overrange after lamp off", {11'd0, lit_lower()}, 32'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule